// File: doc/BRIEF.md
# Paged EEPROM Write Sequencer with Busy Polling

This block sits on the controller side of a two-wire serial bus. It accepts one write request and carries it out against a byte-addressed serial EEPROM. A request gives a start address, a byte count and a stream of data bytes. The block pulls the data bytes one at a time from its data input. It drives a byte-level command port with four operations: START, write-byte, STOP and bus recovery. The bit-level physical layer behind that port answers each command with a completion pulse and, for a write-byte, an acknowledge bit.

The target holds its programming buffer in 8-byte pages. A burst that ran past the end of a page would wrap around inside that page, so the sequencer cuts every request into page-bounded transactions. After each transaction the target spends up to several milliseconds programming. During that time it refuses its address. The sequencer treats that refusal as "still busy" and probes again after a short pause. An overall polling limit turns a target that never answers into an error. That error is followed by a bus-recovery command. A refusal in the middle of a data transaction is a real fault and ends the request.

Top module: `eeprom_wr_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `cmd_valid` are all low.
- R2: A transaction that starts at address A carries at most 8 − (A mod 8) data bytes. A request that crosses a page boundary is split so that the first transaction fills the current page and every later transaction starts on a multiple of 8. Addresses wrap modulo 2^ADDR_W.
- R3: Each write transaction is issued in this order: START (`cmd_op`=0), a write-byte (`cmd_op`=1) of the device byte {4'b1010, `dev_sel`, 1'b0}, a write-byte of the word address, the data bytes in request order, then STOP (`cmd_op`=2). `data_pop` pulses once for each acknowledged data byte.
- R4: After the STOP that ends a write transaction, the block probes with START followed by the device byte. When the probe is acknowledged, it sends STOP and then starts the next transaction, or finishes with `done` high for one cycle and `err` low.
- R5: When a probe is not acknowledged, the block sends STOP and waits at least POLL_GAP cycles with no command outstanding. It then probes again. It raises no error.
- R6: Once POLL_LIMIT cycles of polling have elapsed, the block issues one RECOVER command (`cmd_op`=3). It then pulses `done` and `err` together and abandons the rest of the request.
- R7: A NACK on the device byte, the word address or a data byte of a write transaction causes a STOP, then `done` and `err` together. There is no recovery command, no polling, and no further transaction.
- R8: A request with a byte count of 0 pulses `done` without issuing any command.
- R9: `cmd_valid`, `cmd_op` and `cmd_byte` stay stable until the cycle in which `cmd_done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_sel | input | 3 | Device select bits placed in the device byte |
| req_valid | input | 1 | Request strobe; accepted while `busy` is low |
| req_addr | input | ADDR_W | Start address of the request |
| req_len | input | LEN_W | Number of bytes to write |
| data_in | input | 8 | Current data byte; advances after `data_pop` |
| data_pop | output | 1 | Current data byte has been acknowledged |
| cmd_valid | output | 1 | A command is outstanding |
| cmd_op | output | 2 | 0 START, 1 write-byte, 2 STOP, 3 RECOVER |
| cmd_byte | output | 8 | Byte for a write-byte command |
| cmd_done | input | 1 | Physical layer finished the outstanding command |
| cmd_ack | input | 1 | Acknowledge bit for a write-byte, valid with `cmd_done` |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when a request ends |
| err | output | 1 | Pulses with `done` when the request failed |

## Verification
The bench builds the block with POLL_GAP=4 and POLL_LIMIT=200. At those values a target that never becomes ready exhausts the polling budget after roughly fifteen probes, so the timeout and the recovery path run in a short test. The pause between probes is short but still measurable. ADDR_W stays at 7, so a request that starts near the top of the address space wraps through address 0 and exercises the page split at the wrap point as well.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

  typedef enum logic [1:0] {
    OP_START   = 2'd0,
    OP_WRITE   = 2'd1,
    OP_STOP    = 2'd2,
    OP_RECOVER = 2'd3
  } eewr_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_TSTART, S_TDEV, S_TWADDR, S_TDATA, S_TSTOP,
    S_PSTART, S_PDEV, S_PSTOP, S_PWAIT, S_RECOV, S_ESTOP
  } eewr_st_e;

  // bytes left in the page that holds offset 'offs'
  function automatic int unsigned eewr_room(input int unsigned offs, input int unsigned page);
    return page - offs;
  endfunction

  function automatic int unsigned eewr_min(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/eewr_chunk.sv
module eewr_chunk
  import eewr_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int LEN_W      = 8,
  parameter int PAGE_BYTES = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  remain,
  output logic [LEN_W-1:0]  chunk
);
  localparam int PB_W = $clog2(PAGE_BYTES);

  int unsigned room;

  always_comb begin
    room  = eewr_room(32'(addr[PB_W-1:0]), PAGE_BYTES);
    chunk = LEN_W'(eewr_min(32'(remain), room));
  end
endmodule

// File: rtl/eewr_poll_timer.sv
module eewr_poll_timer #(
  parameter int POLL_GAP   = 1000,
  parameter int POLL_LIMIT = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_total,
  input  logic run_total,
  input  logic gap_run,
  output logic gap_done,
  output logic expired
);
  localparam int GW = $clog2(POLL_GAP + 1);
  localparam int TW = $clog2(POLL_LIMIT + 1);

  logic [GW-1:0] gap_cnt;
  logic [TW-1:0] total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gap_cnt <= '0;
    else if (!gap_run) gap_cnt <= '0;
    else               gap_cnt <= gap_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                total <= '0;
    else if (clr_total)                        total <= '0;
    else if (run_total && total != TW'(POLL_LIMIT)) total <= total + 1'b1;
  end

  assign gap_done = gap_run && (gap_cnt == GW'(POLL_GAP - 1));
  assign expired  = (total == TW'(POLL_LIMIT));

  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    gap_run && !gap_done |=> gap_run) else $error("gap left early"); // R5
endmodule

// File: rtl/eeprom_wr_seq.sv
module eeprom_wr_seq
  import eewr_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int LEN_W      = 8,
  parameter int PAGE_BYTES = 8,
  parameter int POLL_GAP   = 1000,
  parameter int POLL_LIMIT = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        dev_sel,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [7:0]        data_in,
  output logic              data_pop,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [7:0]        cmd_byte,
  input  logic              cmd_done,
  input  logic              cmd_ack,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int PB_W = $clog2(PAGE_BYTES);

  eewr_st_e          state;
  logic [ADDR_W-1:0] addr;
  logic [LEN_W-1:0]  remain, chunk_left, chunk_sz;
  logic              poll_ok, done_q, err_q;
  logic              gap_done, expired;
  eewr_op_e          op_c;

  // named internal events
  logic step, byte_commit, txn_nack, poll_ack, poll_nack, poll_enter, timeout_hit, in_poll;
  assign step        = cmd_valid && cmd_done;
  assign byte_commit = (state == S_TDATA) && step && cmd_ack;
  assign txn_nack    = step && !cmd_ack &&
                       (state == S_TDEV || state == S_TWADDR || state == S_TDATA);
  assign poll_ack    = (state == S_PDEV) && step && cmd_ack;
  assign poll_nack   = (state == S_PDEV) && step && !cmd_ack;
  assign poll_enter  = (state == S_TSTOP) && step;
  assign in_poll     = (state == S_PSTART || state == S_PDEV ||
                        state == S_PSTOP  || state == S_PWAIT);
  assign timeout_hit = (state == S_PWAIT) && gap_done && expired;

  eewr_chunk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
    .addr(addr), .remain(remain), .chunk(chunk_sz)
  );

  eewr_poll_timer #(.POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_total(poll_enter), .run_total(in_poll),
    .gap_run(state == S_PWAIT), .gap_done(gap_done), .expired(expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      addr       <= '0;
      remain     <= '0;
      chunk_left <= '0;
      poll_ok    <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          addr   <= req_addr;
          remain <= req_len;
          if (req_len == '0) done_q <= 1'b1;
          else               state  <= S_TSTART;
        end
        S_TSTART: if (step) begin
          chunk_left <= chunk_sz;
          state      <= S_TDEV;
        end
        S_TDEV:   if (step) state <= cmd_ack ? S_TWADDR : S_ESTOP;
        S_TWADDR: if (step) state <= cmd_ack ? S_TDATA  : S_ESTOP;
        S_TDATA: if (step) begin
          if (!cmd_ack) state <= S_ESTOP;
          else begin
            addr       <= addr + 1'b1;
            remain     <= remain - 1'b1;
            chunk_left <= chunk_left - 1'b1;
            if (chunk_left == LEN_W'(1)) state <= S_TSTOP;
          end
        end
        S_TSTOP:  if (step) state <= S_PSTART;
        S_PSTART: if (step) state <= S_PDEV;
        S_PDEV: if (step) begin
          poll_ok <= cmd_ack;
          state   <= S_PSTOP;
        end
        S_PSTOP: if (step) begin
          if (!poll_ok)           state <= S_PWAIT;
          else if (remain != '0)  state <= S_TSTART;
          else begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        S_PWAIT: if (gap_done) state <= expired ? S_RECOV : S_PSTART;
        S_RECOV, S_ESTOP: if (step) begin
          state  <= S_IDLE;
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      S_TSTART, S_PSTART:       op_c = OP_START;
      S_TSTOP, S_PSTOP, S_ESTOP: op_c = OP_STOP;
      S_RECOV:                  op_c = OP_RECOVER;
      default:                  op_c = OP_WRITE;
    endcase
    unique case (state)
      S_TWADDR: cmd_byte = 8'(addr);
      S_TDATA:  cmd_byte = data_in;
      S_TDEV, S_PDEV: cmd_byte = {4'b1010, dev_sel, 1'b0};
      default:  cmd_byte = 8'h00;
    endcase
  end

  assign cmd_op    = op_c;
  assign cmd_valid = (state != S_IDLE) && (state != S_PWAIT);
  assign data_pop  = byte_commit;
  assign busy      = (state != S_IDLE);
  assign done      = done_q;
  assign err       = err_q;

  AST_PAGE_END: assert property (@(posedge clk) disable iff (!rst_n)
    byte_commit && (addr[PB_W-1:0] == PB_W'(PAGE_BYTES - 1)) |=> state == S_TSTOP)
    else $error("burst crossed a page"); // R2
  AST_CHUNK_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_TWADDR |-> chunk_left != '0 &&
      32'(chunk_left) <= PAGE_BYTES - 32'(addr[PB_W-1:0]))
    else $error("chunk too large"); // R2
  AST_POLL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_PSTART && $past(state) != S_PSTART |->
      $past(state) == S_TSTOP || $past(state) == S_PWAIT)
    else $error("probe without stop"); // R4
  AST_PROBE_NACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    poll_nack |=> !err && state == S_PSTOP)
    else $error("probe nack treated as fault"); // R5
  AST_TIMEOUT_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> state == S_RECOV)
    else $error("timeout without recovery"); // R6
  AST_TXN_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    txn_nack |=> state == S_ESTOP)
    else $error("data nack not stopped"); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy)
    else $error("done while busy"); // R8
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte))
    else $error("command changed early"); // R9
endmodule

// File: tb/tb_eeprom_wr_seq.sv
module tb_eeprom_wr_seq;
  localparam int GAP = 4;
  localparam int LIM = 200;

  logic clk = 0, rst_n = 0;
  logic [2:0] dev_sel = 3'd0;
  logic req_valid = 0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_len = '0;
  logic [7:0] data_in;
  logic data_pop, cmd_valid, cmd_done = 0, cmd_ack = 0, busy, done, err;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;

  eeprom_wr_seq #(.POLL_GAP(GAP), .POLL_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .req_valid(req_valid),
    .req_addr(req_addr), .req_len(req_len), .data_in(data_in), .data_pop(data_pop),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_done(cmd_done),
    .cmd_ack(cmd_ack), .busy(busy), .done(done), .err(err)
  );

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [7:0] src [0:31];
  int ptr = 0;
  assign data_in = src[ptr[4:0]];
  always @(posedge clk) if (data_pop) ptr <= ptr + 1;

  // target model
  logic [7:0] mem [0:127];
  logic [7:0] exp_dev;
  int ph = 0, busy_left = 0, busy_cfg = 3, data_cnt = 0, nack_idx = -1;
  int probe_nacks = 0, recov_n = 0, dev_err = 0, start_n = 0, txn_n = 0;
  int txn_addr [0:15];
  int txn_len  [0:15];
  int t_stop = 0, min_gap = 1000000;
  bit wrote = 0, last_nack = 0, gap_armed = 0, ph_busy = 0, lat_ack = 0;
  logic [6:0] cur;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cmd_done) begin
      cmd_done <= 0; ph_busy = 0;
    end else if (ph_busy) begin
      cmd_done <= 1; cmd_ack <= lat_ack;
    end else if (cmd_valid) begin
      ph_busy = 1; lat_ack = 1;
      case (cmd_op)
        2'd0: begin
          ph = 1; start_n++;
          if (gap_armed) begin
            if (cyc - t_stop < min_gap) min_gap = cyc - t_stop;
            gap_armed = 0;
          end
        end
        2'd1: begin
          if (ph == 1) begin
            if (cmd_byte != exp_dev) begin lat_ack = 0; dev_err++; ph = 4; end
            else if (busy_left > 0) begin
              lat_ack = 0; probe_nacks++; last_nack = 1; ph = 4;
              if (busy_left < 1000) busy_left--;
            end else ph = 2;
          end else if (ph == 2) begin
            cur = cmd_byte[6:0]; txn_addr[txn_n[3:0]] = cmd_byte; txn_len[txn_n[3:0]] = 0;
            txn_n++; ph = 3;
          end else if (ph == 3) begin
            if (data_cnt == nack_idx) lat_ack = 0;
            else begin
              mem[cur] = cmd_byte; txn_len[txn_n[3:0]-1]++; wrote = 1;
              cur = {cur[6:3], cur[2:0] + 3'd1};
            end
            data_cnt++;
          end else lat_ack = 0;
        end
        2'd2: begin
          if (wrote) busy_left = busy_cfg;
          wrote = 0; ph = 0;
          if (last_nack) begin t_stop = cyc; gap_armed = 1; last_nack = 0; end
        end
        default: recov_n++;
      endcase
    end
  end

  task automatic check(input string req, input int act, input int expv);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    nfail++; $display("FAIL watchdog actual=%0d expected=0", cyc);
    summary(); $finish;
  end

  int got_err;
  // run one request; returns err seen with done
  task automatic run_req(input int a, input int n, input int seed);
    int g = 0;
    for (int i = 0; i < 32; i++) src[i] = 8'(seed + i * 7);
    for (int i = 0; i < 128; i++) mem[i] = 8'hEE;
    ptr = 0; data_cnt = 0; busy_left = 0; probe_nacks = 0; recov_n = 0; dev_err = 0;
    start_n = 0; txn_n = 0; wrote = 0; last_nack = 0; gap_armed = 0; min_gap = 1000000;
    exp_dev = {4'hA, dev_sel, 1'b0};
    @(negedge clk);
    req_addr = 7'(a); req_len = 8'(n); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (!done && g < 20000) begin @(negedge clk); g++; end
    got_err = int'(err);
    check("R4 done seen", int'(done), 1);
  endtask

  // expected split and contents computed from R2/R3
  task automatic check_split(input string req, input int a, input int n);
    int k = 0, r = n, x = a, bad = 0;
    while (r > 0) begin
      int c = 8 - (x % 8);
      if (c > r) c = r;
      if (k < txn_n) begin
        if (txn_addr[k] != x || txn_len[k] != c) bad++;
      end
      k++; x = (x + c) % 128; r -= c;
    end
    check({req, " transaction count"}, txn_n, k);
    check({req, " transaction bounds"}, bad, 0);
    bad = 0;
    for (int i = 0; i < n; i++) if (mem[(a + i) % 128] != src[i]) bad++;
    check({req, " data placement"}, bad, 0);
  endtask

  task automatic t_aligned;
    busy_cfg = 3; run_req(16, 8, 1);
    check("R4 aligned no err", got_err, 0);
    check_split("R2 aligned", 16, 8);
    check("R5 probe nacks", probe_nacks, 3);
    check("R5 gap length ok", int'(min_gap >= GAP), 1);
    check("R5 no recovery", recov_n, 0);
  endtask

  task automatic t_unaligned;
    busy_cfg = 2; run_req(5, 10, 40);
    check("R2 unaligned no err", got_err, 0);
    check_split("R2 unaligned", 5, 10);
    check("R4 polls per txn", probe_nacks, 4);
  endtask

  task automatic t_wrap;
    busy_cfg = 1; run_req(126, 20, 90);
    check("R2 wrap no err", got_err, 0);
    check_split("R2 wrap", 126, 20);
  endtask

  task automatic t_devsel;
    dev_sel = 3'd5; busy_cfg = 0; run_req(40, 3, 7);
    check("R3 device byte match", dev_err, 0);
    check("R3 devsel no err", got_err, 0);
    check_split("R3 devsel", 40, 3);
    dev_sel = 3'd0;
  endtask

  task automatic t_data_nack;
    busy_cfg = 3; nack_idx = 2; run_req(48, 6, 3);
    check("R7 error flagged", got_err, 1);
    check("R7 one transaction", txn_n, 1);
    check("R7 only one start", start_n, 1);
    check("R7 no recovery", recov_n, 0);
    check("R7 bytes before nack", int'(mem[48] == src[0] && mem[49] == src[1] && mem[50] == 8'hEE), 1);
    check("R3 pops counted", ptr, 2);
    nack_idx = -1;
  endtask

  task automatic t_timeout;
    busy_cfg = 100000; run_req(32, 12, 11);
    check("R6 error flagged", got_err, 1);
    check("R6 one recovery", recov_n, 1);
    check("R6 rest abandoned", txn_n, 1);
    check("R6 retried", int'(probe_nacks > 1), 1);
    busy_left = 0; busy_cfg = 3;
  endtask

  task automatic t_zero;
    run_req(10, 0, 5);
    check("R8 zero no err", got_err, 0);
    check("R8 no commands", start_n, 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) src[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 err", int'(err), 0);
    check("R1 cmd_valid", int'(cmd_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle after release", int'(busy | cmd_valid), 0);
    t_aligned();
    t_unaligned();
    t_wrap();
    t_devsel();
    t_data_nack();
    t_timeout();
    t_zero();
    t_aligned();
    summary();
    $finish;
  end
endmodule